// File: doc/BRIEF.md
# Multi-Stage Lead-Acid Charge Sequencer

This block is the digital controller of a lead-acid charger. A cycle starts on a request and runs through a constant-current stage and then three constant-voltage stages: absorption, float and a lowered float level. Once it reaches the lowered level, the battery is not left there for good. When a long hold timer expires, the controller raises the battery back to float. After the float timer expires, it lowers the battery again, and this loop repeats with no end.

The controller does not measure time or voltage itself. External duration timers are started by the one-hot stage indicators, and each timer returns a single-cycle expiry strobe. Voltage arrives as comparator flags that are already synchronized and carry their own hysteresis. One flag reports that the bulk threshold has been reached. Each constant-voltage stage has its own flag, which is high while the battery is below that stage's target.

The single charge-enable output behaves differently by stage. In the constant-current stage it is held on. In each constant-voltage stage it follows that stage's own comparator, so the drive pulses and the average voltage settles at the target.

Top module: `chg_stage_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it falls, all stage indicators are low and charge enable is low.
- R2: A rising edge on `start_req`, sampled at a clock edge in any state, makes the bulk indicator (`stage_oh[0]`) high right after that edge.
- R3: Holding `start_req` high for more cycles does not restart the cycle again, so later transitions out of bulk still happen.
- R4: In bulk, `bulk_reached` moves the machine to absorb (`stage_oh[1]`) on the next edge. `bulk_reached` has no effect in any other stage, and timer strobes have no effect in bulk.
- R5: In absorb, `absorb_done` moves the machine to float (`stage_oh[2]`). The other strobes have no effect in absorb.
- R6: In float, `float_done` moves the machine to reduced float (`stage_oh[3]`). The other strobes have no effect in float.
- R7: In reduced float, `rfloat_done` moves the machine back to float. The float to reduced-float loop then repeats.
- R8: At most one bit of `stage_oh` is high at any time. Exactly one is high in every stage except idle, and none is high in idle.
- R9: In bulk, `chg_en` is high regardless of the regulation flags.
- R10: In absorb, float and reduced float, `chg_en` equals `reg_absorb`, `reg_float` or `reg_rfloat` respectively. The other two flags have no effect.
- R11: In idle, `chg_en` is low, and no strobe or comparator flag leaves idle without a start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin a new charge cycle (rising edge acts) |
| bulk_reached | input | 1 | Battery has reached the bulk voltage |
| reg_absorb | input | 1 | Battery below the absorb target |
| reg_float | input | 1 | Battery below the float target |
| reg_rfloat | input | 1 | Battery below the reduced-float target |
| absorb_done | input | 1 | Absorb timer expiry strobe |
| float_done | input | 1 | Float timer expiry strobe |
| rfloat_done | input | 1 | Reduced-float timer expiry strobe |
| stage_oh | output | 4 | One-hot stage: [0] bulk, [1] absorb, [2] float, [3] reduced float |
| chg_en | output | 1 | Charge drive enable |

## Verification
The hardest situation to reach is the repeating float and reduced-float loop after a long hold. To reach it, the stimulus walks the machine through every stage with single-cycle strobes and then fires the reduced-float and float strobes back to back several times. Inside each stage, the stimulus also applies every stray strobe alone and all eight combinations of the regulation flags. This shows that only the stage's own event and its own comparator have any effect. A restart is raised from each stage in turn, and `start_req` is held high across later transitions to confirm that only its edge counts.

// File: rtl/chg_pkg.sv
package chg_pkg;

    localparam int STAGE_CNT = 4;
    localparam int CV_CNT    = STAGE_CNT - 1;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BULK   = 3'd1,
        ST_ABSORB = 3'd2,
        ST_FLOAT  = 3'd3,
        ST_RFLOAT = 3'd4
    } stage_e;

    typedef struct packed {
        logic bulk_hit;
        logic absorb_exp;
        logic float_exp;
        logic rfloat_exp;
    } evt_t;

    function automatic logic [STAGE_CNT-1:0] stage_to_oh(stage_e s);
        logic [STAGE_CNT-1:0] oh;
        oh = '0;
        case (s)
            ST_BULK:   oh[0] = 1'b1;
            ST_ABSORB: oh[1] = 1'b1;
            ST_FLOAT:  oh[2] = 1'b1;
            ST_RFLOAT: oh[3] = 1'b1;
            default:   oh = '0;
        endcase
        return oh;
    endfunction

endpackage

// File: rtl/chg_start_edge.sv
module chg_start_edge (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic pulse
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req;
    end

    assign pulse = req & ~req_q;
endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
    import chg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  evt_t   evt,
    output stage_e stage
);
    stage_e nxt;

    always_comb begin
        nxt = stage;
        if (restart) begin
            nxt = ST_BULK;
        end else begin
            case (stage)
                ST_BULK:   if (evt.bulk_hit)   nxt = ST_ABSORB;
                ST_ABSORB: if (evt.absorb_exp) nxt = ST_FLOAT;
                ST_FLOAT:  if (evt.float_exp)  nxt = ST_RFLOAT;
                ST_RFLOAT: if (evt.rfloat_exp) nxt = ST_FLOAT;
                default:   nxt = stage;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage <= ST_IDLE;
        else     stage <= nxt;
    end
endmodule

// File: rtl/chg_drive_mux.sv
module chg_drive_mux
    import chg_pkg::*;
(
    input  logic [STAGE_CNT-1:0] stage_oh,
    input  logic [CV_CNT-1:0]    cv_below,
    output logic                 drive
);
    logic [CV_CNT-1:0] term;

    for (genvar i = 0; i < CV_CNT; i++) begin : g_cv
        assign term[i] = stage_oh[i+1] & cv_below[i];
    end

    assign drive = stage_oh[0] | (|term);
endmodule

// File: rtl/chg_stage_ctrl.sv
module chg_stage_ctrl
    import chg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_req,
    input  logic                 bulk_reached,
    input  logic                 reg_absorb,
    input  logic                 reg_float,
    input  logic                 reg_rfloat,
    input  logic                 absorb_done,
    input  logic                 float_done,
    input  logic                 rfloat_done,
    output logic [STAGE_CNT-1:0] stage_oh,
    output logic                 chg_en
);
    logic   start_pulse;
    evt_t   evt;
    stage_e stage;

    chg_start_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .req   (start_req),
        .pulse (start_pulse)
    );

    assign evt.bulk_hit   = bulk_reached;
    assign evt.absorb_exp = absorb_done;
    assign evt.float_exp  = float_done;
    assign evt.rfloat_exp = rfloat_done;

    chg_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .restart (start_pulse),
        .evt     (evt),
        .stage   (stage)
    );

    assign stage_oh = stage_to_oh(stage);

    chg_drive_mux u_drv (
        .stage_oh (stage_oh),
        .cv_below ({reg_rfloat, reg_float, reg_absorb}),
        .drive    (chg_en)
    );
endmodule

// File: rtl/chg_stage_chk.sv
module chg_stage_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_req,
    input logic       bulk_reached,
    input logic       reg_absorb,
    input logic       reg_float,
    input logic       reg_rfloat,
    input logic       absorb_done,
    input logic       float_done,
    input logic       rfloat_done,
    input logic [3:0] stage_oh,
    input logic       chg_en
);
    // R1: after a reset cycle, idle with drive off
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (stage_oh == 4'b0) && !chg_en);

    // R8: never more than one stage indicator
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage_oh));

    // R2: start edge lands in bulk
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        (start_req && !$past(start_req)) |=> stage_oh[0]);

    // R6: float expiry steps to reduced float
    a_r6_float_exit: assert property (@(posedge clk) disable iff (rst)
        (stage_oh[2] && float_done && !(start_req && !$past(start_req)))
        |=> stage_oh[3]);

    // R7: reduced float expiry returns to float
    a_r7_rfloat_exit: assert property (@(posedge clk) disable iff (rst)
        (stage_oh[3] && rfloat_done && !(start_req && !$past(start_req)))
        |=> stage_oh[2]);

    // R9: constant current in bulk
    a_r9_bulk_drive: assert property (@(posedge clk) disable iff (rst)
        stage_oh[0] |-> chg_en);

    // R10: CV drive follows the active stage comparator
    a_r10_cv_drive: assert property (@(posedge clk) disable iff (rst)
        (stage_oh[1] |-> chg_en == reg_absorb) and
        (stage_oh[2] |-> chg_en == reg_float) and
        (stage_oh[3] |-> chg_en == reg_rfloat));

    // R11: idle never drives
    a_r11_idle_off: assert property (@(posedge clk) disable iff (rst)
        (stage_oh == 4'b0) |-> !chg_en);
endmodule

bind chg_stage_ctrl chg_stage_chk u_chk (.*);

// File: tb/tb_chg_stage_ctrl.sv
`timescale 1ns/1ps
module tb_chg_stage_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 0, bulk_reached = 0;
    logic reg_absorb = 0, reg_float = 0, reg_rfloat = 0;
    logic absorb_done = 0, float_done = 0, rfloat_done = 0;
    logic [3:0] stage_oh;
    logic chg_en;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    localparam logic [3:0] OH_IDLE = 4'b0000, OH_BULK = 4'b0001,
        OH_ABS = 4'b0010, OH_FLT = 4'b0100, OH_RFL = 4'b1000;

    always #2 clk = ~clk;

    chg_stage_ctrl dut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_stage(logic [3:0] exp, string req);
        chk(stage_oh === exp, req, stage_oh, exp);
    endtask

    task automatic pulse_evt(int which);
        case (which)
            0: bulk_reached = 1;
            1: absorb_done  = 1;
            2: float_done   = 1;
            default: rfloat_done = 1;
        endcase
        step();
        bulk_reached = 0; absorb_done = 0; float_done = 0; rfloat_done = 0;
    endtask

    // every stray event leaves the stage alone
    task automatic stray(logic [3:0] oh, int own, string req);
        for (int e = 0; e < 4; e++) begin
            if (e != own) begin
                pulse_evt(e);
                chk_stage(oh, req);
            end
        end
    endtask

    // sweep all regulation flag combinations
    task automatic flag_sweep(int sel, string req);
        for (int f = 0; f < 8; f++) begin
            {reg_rfloat, reg_float, reg_absorb} = f[2:0];
            #1;
            if (sel < 0) chk(chg_en === 1'b0, req, chg_en, 0);
            else if (sel == 0) chk(chg_en === 1'b1, req, chg_en, 1);
            else chk(chg_en === f[sel-1], req, chg_en, f[sel-1]);
        end
        {reg_rfloat, reg_float, reg_absorb} = 3'b000;
    endtask

    task automatic restart();
        start_req = 1; step(); start_req = 0;
        chk_stage(OH_BULK, "R2");
        step();
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        reg_absorb = 1; reg_float = 1; reg_rfloat = 1;
        step(); step();
        chk_stage(OH_IDLE, "R1");
        chk(chg_en === 1'b0, "R1", chg_en, 0);
        rst = 0; step();
        chk_stage(OH_IDLE, "R1");
        chk(chg_en === 1'b0, "R1", chg_en, 0);

        // R11: idle ignores everything but a start edge
        stray(OH_IDLE, -1, "R11");
        flag_sweep(-1, "R11");

        // R2/R3: start held high, edge counted once
        start_req = 1; step();
        chk_stage(OH_BULK, "R2");
        step(); step();
        chk_stage(OH_BULK, "R3");
        flag_sweep(0, "R9");
        stray(OH_BULK, 0, "R4");
        pulse_evt(0);
        chk_stage(OH_ABS, "R3");
        step();
        chk_stage(OH_ABS, "R3");
        start_req = 0; step();

        // absorb
        flag_sweep(1, "R10");
        stray(OH_ABS, 1, "R5");
        pulse_evt(1);
        chk_stage(OH_FLT, "R5");

        // float
        flag_sweep(2, "R10");
        stray(OH_FLT, 2, "R6");
        pulse_evt(2);
        chk_stage(OH_RFL, "R6");

        // reduced float
        flag_sweep(3, "R10");
        stray(OH_RFL, 3, "R7");
        chk(stage_oh === OH_RFL, "R4", stage_oh, OH_RFL);

        // R7: repeating loop
        for (int k = 0; k < 4; k++) begin
            pulse_evt(3);
            chk_stage(OH_FLT, "R7");
            chk(($countones(stage_oh) == 1), "R8", $countones(stage_oh), 1);
            pulse_evt(2);
            chk_stage(OH_RFL, "R7");
        end

        // R2: restart from each stage
        restart();
        pulse_evt(0); chk_stage(OH_ABS, "R4");
        restart();
        pulse_evt(0); pulse_evt(1); chk_stage(OH_FLT, "R5");
        restart();
        pulse_evt(0); pulse_evt(1); pulse_evt(2); chk_stage(OH_RFL, "R6");
        restart();
        chk(chg_en === 1'b1, "R9", chg_en, 1);

        // R1: reset mid-cycle returns to idle
        rst = 1; step();
        chk_stage(OH_IDLE, "R1");
        chk(chg_en === 1'b0, "R1", chg_en, 0);
        rst = 0; step();
        chk_stage(OH_IDLE, "R1");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule